// File: doc/BRIEF.md
# Integer ALU with Compare

A purely combinational arithmetic-logic unit for a three-operand integer datapath. Two operand words, a shift distance and a 4-bit operation code go in. A result word and a zero flag come out in the same cycle. The branch-compare logic downstream uses the zero flag: it selects subtract and tests the flag to decide equality.

The unit covers the following operations:
- add and subtract, both wrapping;
- AND, OR and NOR;
- left and right logical shifts;
- signed and unsigned less-than, each returning 0 or 1;
- an upper-half immediate load.

Immediate extension happens before the unit. Because no subtract-immediate code exists, a constant is subtracted by adding its negative, already sign-extended.

Top module: `alu_core`

## Requirements
- R1: Code 0 (add) returns a_i + b_i modulo 2^32 with no exception; 0xFFFFFFFF + 1 gives 0.
- R2: Code 1 (subtract) returns a_i - b_i modulo 2^32; 0 - 1 gives 0xFFFFFFFF.
- R3: Code 2 returns the bitwise AND of a_i and b_i; code 3 returns their bitwise OR.
- R4: Code 4 returns ~(a_i | b_i); with b_i = 0 this is the bitwise complement of a_i.
- R5: Code 5 shifts a_i left by shamt_i (0 to 31) and fills the vacated positions with 0.
- R6: Code 6 shifts a_i right by shamt_i (0 to 31) and fills the vacated positions with 0.
- R7: Code 7 returns 1 when a_i < b_i as two's-complement values (bit 31 is the sign), otherwise 0; a_i = 0xFFFFFFFF with b_i = 1 gives 1.
- R8: Code 8 returns 1 when a_i < b_i as unsigned values, otherwise 0; a_i = 0xFFFFFFFF with b_i = 1 gives 0.
- R9: Code 9 places b_i[15:0] in result bits 31:16 and clears bits 15:0; a_i and b_i[31:16] have no effect.
- R10: zero_o is 1 exactly when result_o is all zeros, so under subtract it reports a_i == b_i.
- R11: Codes 10 to 15 return 0, which sets zero_o.
- R12: Adding a sign-extended negative constant under code 0 yields a_i minus that constant's magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand, and the word that is shifted |
| b_i | input | 32 | Second operand; its low half is the upper-load constant |
| shamt_i | input | 5 | Shift distance |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | High when result_o is zero |

## Verification
The bench targets operand pairs where signed and unsigned order disagree, such as all-ones against one and most-negative against most-positive. A compare built on the raw difference sign would get the signed case wrong, and one that ignores the borrow would get the unsigned case wrong.

Shifts are exercised at distances 0, 1, 16 and 31. A shifter that sign-fills or drops a stage would leave stray ones or lose bits at those distances.

The add and subtract wrap points, and the upper load with junk in a_i and in the high half of b_i, are also covered. Unused codes are checked to confirm they return 0 and raise the flag, where a careless decoder would return a neighbouring operation.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SHAMT_W = $clog2(DATA_W);
  localparam int unsigned OP_W    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SLT  = 4'd7,
    OP_SLTU = 4'd8,
    OP_LUI  = 4'd9
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  logic [W-1:0] b_x;
  logic [W:0]   sum_ext;

  assign b_x     = sub_i ? ~b_i : b_i;
  assign sum_ext = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, sub_i};
  assign sum_o   = sum_ext[W-1:0];
  // borrow is the inverted carry of a + ~b + 1
  assign lt_u_o  = ~sum_ext[W];
  assign lt_s_o  = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : sum_ext[W-1];

  always_comb begin
    if (sub_i && !$isunknown({a_i, b_i})) begin
      a_r8_unsigned_lt: assert (lt_u_o == (a_i < b_i));
      a_r7_signed_lt:   assert (lt_s_o == ($signed(a_i) < $signed(b_i)));
    end
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned W    = 32,
  parameter int unsigned SH_W = 5,
  parameter bit          LEFT = 1'b1
) (
  input  logic [W-1:0]    a_i,
  input  logic [SH_W-1:0] shamt_i,
  output logic [W-1:0]    y_o
);
  logic [W-1:0] stage [SH_W+1];

  assign stage[0] = a_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int unsigned DIST = 1 << k;
    if (LEFT) begin : g_l
      assign stage[k+1] = shamt_i[k] ? (stage[k] << DIST) : stage[k];
    end else begin : g_r
      assign stage[k+1] = shamt_i[k] ? (stage[k] >> DIST) : stage[k];
    end
  end

  assign y_o = stage[SH_W];

  always_comb begin
    if (!$isunknown({a_i, shamt_i}) && shamt_i == '0)
      a_r5_r6_zero_shift: assert (y_o == a_i);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] nor_o,
  output logic [W-1:0] lui_o
);
  localparam int unsigned HALF = W / 2;

  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign nor_o = ~or_o;
  assign lui_o = {b_i[HALF-1:0], {HALF{1'b0}}};
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
(
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  input  logic [4:0]  shamt_i,
  input  logic [3:0]  op_i,
  output logic [31:0] result_o,
  output logic        zero_o
);
  localparam int unsigned W    = DATA_W;
  localparam int unsigned HALF = W / 2;

  logic         sub_sel;
  logic [W-1:0] sum, and_w, or_w, nor_w, lui_w, sll_w, srl_w;
  logic         lt_s, lt_u;

  // subtract path also serves both compares
  assign sub_sel = (op_i == OP_SUB) || (op_i == OP_SLT) || (op_i == OP_SLTU);

  alu_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_sel),
    .sum_o(sum), .lt_s_o(lt_s), .lt_u_o(lt_u)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i(a_i), .b_i(b_i),
    .and_o(and_w), .or_o(or_w), .nor_o(nor_w), .lui_o(lui_w)
  );

  alu_shift #(.W(W), .SH_W(SHAMT_W), .LEFT(1'b1)) u_sll (
    .a_i(a_i), .shamt_i(shamt_i), .y_o(sll_w)
  );

  alu_shift #(.W(W), .SH_W(SHAMT_W), .LEFT(1'b0)) u_srl (
    .a_i(a_i), .shamt_i(shamt_i), .y_o(srl_w)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB: result_o = sum;
      OP_AND:         result_o = and_w;
      OP_OR:          result_o = or_w;
      OP_NOR:         result_o = nor_w;
      OP_SLL:         result_o = sll_w;
      OP_SRL:         result_o = srl_w;
      OP_SLT:         result_o = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:        result_o = {{(W-1){1'b0}}, lt_u};
      OP_LUI:         result_o = lui_w;
      default:        result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;

  always_comb begin
    if (!$isunknown({a_i, b_i, shamt_i, op_i})) begin
      if (op_i == OP_SUB)
        a_r10_sub_equal: assert (zero_o == (a_i == b_i));
      if (op_i == OP_ADD)
        a_r1_add_wrap: assert (result_o == W'(a_i + b_i));
      if (op_i == OP_SLT || op_i == OP_SLTU)
        a_r7_r8_bool: assert (result_o[W-1:1] == '0);
      if (op_i == OP_LUI)
        a_r9_low_clear: assert (result_o[HALF-1:0] == '0 && result_o[W-1:HALF] == b_i[HALF-1:0]);
      if (op_i > OP_LUI)
        a_r11_unused_zero: assert (result_o == '0 && zero_o);
    end
  end
endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b;
  logic [4:0]  sh;
  logic [3:0]  op;
  logic [31:0] res;
  logic        zf;
  int          n_checks = 0;
  int          n_errors = 0;

  always #4 clk = ~clk;

  alu_core u0 (
    .a_i(a), .b_i(b), .shamt_i(sh), .op_i(op),
    .result_o(res), .zero_o(zf)
  );

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input logic [4:0] s);
    case (o)
      4'd0: return x + y;
      4'd1: return x - y;
      4'd2: return x & y;
      4'd3: return x | y;
      4'd4: return ~(x | y);
      4'd5: return x << s;
      4'd6: return x >> s;
      4'd7: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'd8: return (x < y) ? 32'd1 : 32'd0;
      4'd9: return {y[15:0], 16'h0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic run(input string tag, input logic [3:0] o, input logic [31:0] x,
                     input logic [31:0] y, input logic [4:0] s, input logic [31:0] exp);
    @(posedge clk);
    op = o; a = x; b = y; sh = s;
    @(negedge clk);
    n_checks++;
    if (res !== exp || zf !== (exp == 32'd0)) begin
      n_errors++;
      $display("FAIL %s op=%0d res=%h zero=%b expected res=%h zero=%b",
               tag, o, res, zf, exp, exp == 32'd0);
    end
  endtask

  task automatic t_reset;
    run("R10 idle", 4'd0, 32'd0, 32'd0, 5'd0, 32'd0);
  endtask

  task automatic t_add;
    run("R1", 4'd0, 32'hFFFFFFFF, 32'd1, 5'd0, 32'd0);
    run("R1", 4'd0, 32'd1234, 32'd4321, 5'd0, 32'd5555);
    run("R1", 4'd0, 32'h7FFFFFFF, 32'd1, 5'd0, 32'h80000000);
  endtask

  task automatic t_addi_neg;
    run("R12", 4'd0, 32'd100, 32'hFFFFFFFD, 5'd0, 32'd97);
    run("R12", 4'd0, 32'd2, 32'hFFFFFFFE, 5'd0, 32'd0);
  endtask

  task automatic t_sub;
    run("R2", 4'd1, 32'd0, 32'd1, 5'd0, 32'hFFFFFFFF);
    run("R2", 4'd1, 32'd50, 32'd8, 5'd0, 32'd42);
    run("R10", 4'd1, 32'hDEADBEEF, 32'hDEADBEEF, 5'd0, 32'd0);
    run("R10", 4'd1, 32'hDEADBEEF, 32'hDEADBEEE, 5'd0, 32'd1);
  endtask

  task automatic t_logic;
    run("R3 and", 4'd2, 32'h00000DC0, 32'h00003C00, 5'd0, 32'h00000C00);
    run("R3 or",  4'd3, 32'h00000DC0, 32'h00003C00, 5'd0, 32'h00003DC0);
    run("R4 not", 4'd4, 32'h00003C00, 32'd0, 5'd0, 32'hFFFFC3FF);
    run("R4 nor", 4'd4, 32'hF0F0F0F0, 32'h0F0F0F0F, 5'd0, 32'd0);
  endtask

  task automatic t_shift;
    run("R5", 4'd5, 32'h80000001, 32'd0, 5'd0, 32'h80000001);
    run("R5", 4'd5, 32'h80000001, 32'd0, 5'd1, 32'h00000002);
    run("R5", 4'd5, 32'hFFFFFFFF, 32'd0, 5'd31, 32'h80000000);
    run("R5", 4'd5, 32'h0001ABCD, 32'd0, 5'd16, 32'hABCD0000);
    run("R6", 4'd6, 32'h80000000, 32'd0, 5'd31, 32'd1);
    run("R6", 4'd6, 32'hFFFFFFFF, 32'd0, 5'd1, 32'h7FFFFFFF);
    run("R6", 4'd6, 32'hABCD1234, 32'd0, 5'd16, 32'h0000ABCD);
  endtask

  task automatic t_compare;
    run("R7", 4'd7, 32'hFFFFFFFF, 32'd1, 5'd0, 32'd1);
    run("R8", 4'd8, 32'hFFFFFFFF, 32'd1, 5'd0, 32'd0);
    run("R7", 4'd7, 32'h80000000, 32'h7FFFFFFF, 5'd0, 32'd1);
    run("R8", 4'd8, 32'h80000000, 32'h7FFFFFFF, 5'd0, 32'd0);
    run("R7", 4'd7, 32'd5, 32'd5, 5'd0, 32'd0);
    run("R8", 4'd8, 32'd4, 32'd5, 5'd0, 32'd1);
  endtask

  task automatic t_lui;
    run("R9", 4'd9, 32'h12345678, 32'hFFFF003D, 5'd7, 32'h003D0000);
    run("R9", 4'd9, 32'hFFFFFFFF, 32'hABCD0000, 5'd0, 32'd0);
  endtask

  task automatic t_unused;
    for (int c = 10; c < 16; c++)
      run("R11", 4'(c), 32'hFFFFFFFF, 32'h12345678, 5'd3, 32'd0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      logic [4:0]  s;
      logic [3:0]  o;
      x = $urandom; y = $urandom; s = 5'($urandom); o = 4'($urandom_range(0, 15));
      if (i % 7 == 0) y = x;
      run("R1..R11 random", o, x, y, s, model(o, x, y, s));
    end
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    a = '0; b = '0; sh = '0; op = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_add();
    t_addi_neg();
    t_sub();
    t_logic();
    t_shift();
    t_compare();
    t_lui();
    t_unused();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule